// File: doc/BRIEF.md
# Dual-Channel Simultaneous-Sampling ADC Serial Reader

This block is the host side of a serial link to a two-channel ADC that converts both channels at the same instant. A one-cycle start request opens a frame. The block pulls the active-low select line down and then toggles the serial clock a fixed number of times. It captures both signed 14-bit conversion results, widens them to 16 bits and presents them together with a one-cycle valid strobe. During the first part of every frame the converter is busy and its data lines float, so the reader takes no data until the converter launches the most significant bit on the 19th falling clock edge.

There are two capture modes, chosen when the frame starts. In dual-line mode both results arrive at the same time, one on each data line, and the frame is 33 serial clocks long. In single-line mode the select line is held for 14 more clocks. The second channel's result then follows the first on line A, and the frame is 47 clocks long. A parameter sets the length of each serial clock phase in system clocks.

The sequencer has five states. The transitions are:
- IDLE goes to SETUP on an accepted start.
- SETUP goes to LOW when the phase time has elapsed.
- LOW goes to HIGH when the phase time has elapsed. The data sample is taken on this transition.
- HIGH goes back to LOW when the phase time has elapsed and the edge count is short of the frame length.
- HIGH goes to DONE when the phase time has elapsed and the edge count has reached the frame length.
- DONE goes to IDLE unconditionally.

Top module: `dual_adc_reader`

## Requirements
- R1: After reset, select_n is 1, the serial clock is 1, busy and valid are 0, and both results are 0.
- R2: The serial clock stays high whenever select_n is high. After select_n falls, the clock stays high for at least one phase (HALF_DIV system clocks) before its first falling edge.
- R3: When mode_single is 0 at start, the frame has exactly 33 falling serial clock edges. select_n rises with the clock high, after the last rising edge.
- R4: When mode_single is 1 at start, the frame has exactly 47 falling serial clock edges.
- R5: Each bit is taken at the rising serial clock edge that follows the falling edge that launched it. The results are sent MSB first on falling edges 19 to 32. In dual-line mode, channel A comes from line A and channel B from line B.
- R6: In single-line mode, channel A is taken from line A on edges 19 to 32, and channel B from line A on falling edges 34 to 47. Line B is ignored.
- R7: The data lines are ignored outside the capture windows. This covers the conversion interval (edges 1 to 18) and edge 33.
- R8: Each 14-bit two's-complement result is sign-extended to 16 bits. Bit 13 is copied into bits 15 and 14.
- R9: valid is high for exactly one system clock per frame. Both results change on that cycle and hold until the next frame completes.
- R10: busy is high from the cycle after an accepted start until the cycle valid is high, when it is 0. A start while busy is ignored.
- R11: The mode is latched at start. Changing mode_single during a frame does not change that frame's length or capture.
- R12: Each low phase of the serial clock lasts HALF_DIV system clocks (HALF_DIV at least 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to read one conversion |
| mode_single_i | input | 1 | 1 = single-line capture (47 clocks), 0 = dual-line capture (33 clocks) |
| sdo_a_i | input | 1 | Serial data line A from the converter |
| sdo_b_i | input | 1 | Serial data line B from the converter |
| sel_n_o | output | 1 | Active-low select to the converter |
| sclk_o | output | 1 | Serial clock to the converter, idles high |
| busy_o | output | 1 | Frame in progress |
| valid_o | output | 1 | One-cycle strobe: results updated |
| res_a_o | output | 16 | Channel A result, sign-extended |
| res_b_o | output | 16 | Channel B result, sign-extended |

## Verification
The converter model drives toggling noise during the float interval, on edge 33, and on line B in single-line mode. A reader that opened its capture window one edge early or late would shift that noise into the results. Values at both extremes of the signed range expose a missing or wrong sign extension. A start request and a mode flip in the middle of a frame catch a controller that restarts the frame, re-latches the mode, or emits a second valid. Counts of clock edges and phase lengths catch an off-by-one in the frame length or the divider.

// File: rtl/rdr_pkg.sv
package rdr_pkg;
    localparam int DATA_W      = 14;
    localparam int RES_W       = 16;
    localparam int EDGES_DUAL  = 33;
    localparam int EDGES_CHAIN = 14;
    localparam int EDGES_SGL   = EDGES_DUAL + EDGES_CHAIN;
    localparam int FIRST_BIT   = 19;
    localparam int LAST_BIT_A  = FIRST_BIT + DATA_W - 1;
    localparam int FIRST_BIT_B = EDGES_DUAL + 1;
    localparam int LAST_BIT_B  = FIRST_BIT_B + DATA_W - 1;
    localparam int CNT_W       = $clog2(EDGES_SGL + 1);

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP,
        S_LOW,
        S_HIGH,
        S_DONE
    } rdr_state_e;
endpackage

// File: rtl/rdr_tick.sv
module rdr_tick #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // R12
    tick_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/rdr_shift.sv
module rdr_shift #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (en)
            q <= {q[W-2:0], din};
    end
endmodule

// File: rtl/rdr_seq.sv
module rdr_seq
    import rdr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic mode_single,
    input  logic tick,
    output logic run,
    output logic sel_n,
    output logic sclk,
    output logic samp_a,
    output logic samp_b,
    output logic single_q,
    output logic load,
    output logic busy,
    output logic valid
);
    localparam logic [CNT_W-1:0] C_FIRST  = CNT_W'(FIRST_BIT);
    localparam logic [CNT_W-1:0] C_LASTA  = CNT_W'(LAST_BIT_A);
    localparam logic [CNT_W-1:0] C_FIRSTB = CNT_W'(FIRST_BIT_B);
    localparam logic [CNT_W-1:0] C_LASTB  = CNT_W'(LAST_BIT_B);
    localparam logic [CNT_W-1:0] C_DUAL   = CNT_W'(EDGES_DUAL);
    localparam logic [CNT_W-1:0] C_SGL    = CNT_W'(EDGES_SGL);

    rdr_state_e       state_q, state_d;
    logic [CNT_W-1:0] edge_q;
    logic [CNT_W-1:0] last_edge;
    logic             win_a, win_b2, at_last;

    assign last_edge = single_q ? C_SGL : C_DUAL;
    assign at_last   = (edge_q == last_edge);
    assign win_a     = (edge_q >= C_FIRST) && (edge_q <= C_LASTA);
    assign win_b2    = (edge_q >= C_FIRSTB) && (edge_q <= C_LASTB);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = S_SETUP;
            S_SETUP: if (tick) state_d = S_LOW;
            S_LOW:   if (tick) state_d = S_HIGH;
            S_HIGH:  if (tick) state_d = at_last ? S_DONE : S_LOW;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_q   <= '0;
            single_q <= 1'b0;
        end else begin
            if (state_q == S_IDLE && start) begin
                edge_q   <= '0;
                single_q <= mode_single;
            end else if (state_d == S_LOW && tick) begin
                edge_q <= edge_q + 1'b1;
            end
        end
    end

    always_comb begin
        run    = (state_q == S_SETUP) || (state_q == S_LOW) || (state_q == S_HIGH);
        sel_n  = (state_q == S_IDLE) || (state_q == S_DONE);
        sclk   = (state_q != S_LOW);
        busy   = run;
        valid  = (state_q == S_DONE);
        load   = (state_q == S_HIGH) && tick && at_last;
        samp_a = (state_q == S_LOW) && tick && win_a;
        samp_b = (state_q == S_LOW) && tick && (single_q ? win_b2 : win_a);
    end

    // R9
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);
    // R2
    idle_clk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |-> sclk);
    // R3
    edge_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_q <= last_edge);
    // R10
    busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && start) |=> busy);
    // R11
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state_q != S_IDLE) |=> $stable(single_q));
    // R10
    valid_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> !busy);
endmodule

// File: rtl/dual_adc_reader.sv
module dual_adc_reader
    import rdr_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             mode_single_i,
    input  logic             sdo_a_i,
    input  logic             sdo_b_i,
    output logic             sel_n_o,
    output logic             sclk_o,
    output logic             busy_o,
    output logic             valid_o,
    output logic [RES_W-1:0] res_a_o,
    output logic [RES_W-1:0] res_b_o
);
    localparam int NCH = 2;
    localparam int EXT = RES_W - DATA_W;

    logic run, tick, samp_a, samp_b, single_q, load;
    logic [NCH-1:0]   sh_en, sh_din;
    logic [DATA_W-1:0] sh_q [NCH];

    rdr_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
    );

    rdr_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start(start_i), .mode_single(mode_single_i),
        .tick(tick), .run(run), .sel_n(sel_n_o), .sclk(sclk_o),
        .samp_a(samp_a), .samp_b(samp_b), .single_q(single_q), .load(load),
        .busy(busy_o), .valid(valid_o)
    );

    assign sh_en[0]  = samp_a;
    assign sh_din[0] = sdo_a_i;
    assign sh_en[1]  = samp_b;
    assign sh_din[1] = single_q ? sdo_a_i : sdo_b_i;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        rdr_shift #(.W(DATA_W)) u_sh (
            .clk(clk), .rst_n(rst_n), .en(sh_en[g]), .din(sh_din[g]), .q(sh_q[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_a_o <= '0;
            res_b_o <= '0;
        end else if (load) begin
            res_a_o <= {{EXT{sh_q[0][DATA_W-1]}}, sh_q[0]};
            res_b_o <= {{EXT{sh_q[1][DATA_W-1]}}, sh_q[1]};
        end
    end

    // R9
    res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(res_a_o) && $stable(res_b_o));
    // R8
    sign_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (res_a_o[RES_W-1] == res_a_o[DATA_W-1]) && (res_b_o[RES_W-1] == res_b_o[DATA_W-1]));
    // R6
    no_b_sample_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n_o |-> !(samp_a || samp_b));
endmodule

// File: tb/test_dual_adc_reader.sv
module test_dual_adc_reader;
    localparam int CLK_P = 10;
    localparam int HALF  = 2;
    localparam int NVEC  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, mode = 1'b0;
    logic sdo_a = 1'b1, sdo_b = 1'b1;
    logic sel_n, sclk, busy, valid;
    logic [15:0] res_a, res_b;

    int errors = 0, checks = 0;
    int falls = 0, setup_len = 0, low_run = 0, bad_low = 0, valids = 0;
    logic [13:0] adc_a = '0, adc_b = '0;

    always #(CLK_P/2) clk = ~clk;

    dual_adc_reader #(.HALF_DIV(HALF)) i_dual_adc_reader (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mode_single_i(mode),
        .sdo_a_i(sdo_a), .sdo_b_i(sdo_b), .sel_n_o(sel_n), .sclk_o(sclk),
        .busy_o(busy), .valid_o(valid), .res_a_o(res_a), .res_b_o(res_b)
    );

    // converter model: launches on falling serial clock edges, noise elsewhere
    always @(negedge sel_n) falls = 0;
    always @(negedge sclk) begin
        if (!sel_n) begin
            falls = falls + 1;
            if (falls >= 19 && falls <= 32) begin
                sdo_a <= adc_a[13 - (falls - 19)];
                sdo_b <= adc_b[13 - (falls - 19)];
            end else if (falls >= 34 && falls <= 47) begin
                sdo_a <= adc_b[13 - (falls - 34)];
                sdo_b <= falls[0];
            end else begin
                sdo_a <= ~falls[0];
                sdo_b <= falls[0];
            end
        end
    end

    always @(negedge clk) begin
        if (valid) valids = valids + 1;
        if (!sel_n && sclk && falls == 0) setup_len = setup_len + 1;
        if (!sclk) low_run = low_run + 1;
        else if (low_run != 0) begin
            if (low_run != HALF) bad_low = bad_low + 1;
            low_run = 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_valid(input int limit);
        for (int i = 0; i < limit && !valid; i++) @(negedge clk);
    endtask

    task automatic run_frame(input bit m, input logic [13:0] a, input logic [13:0] b);
        logic [15:0] ea, eb;
        adc_a = a; adc_b = b;
        setup_len = 0; valids = 0;
        @(negedge clk); start = 1'b1; mode = m;
        @(negedge clk); start = 1'b0;
        chk(busy == 1'b1, "R10 busy after start", busy, 1);
        wait_valid(2000);
        ea = {{2{a[13]}}, a};
        eb = {{2{b[13]}}, b};
        chk(valid == 1'b1, "R9 valid seen", valid, 1);
        // R5 R6 R7 R8 captured data, sign-extended
        chk(res_a == ea, m ? "R6 R8 chan A" : "R5 R8 chan A", res_a, ea);
        chk(res_b == eb, m ? "R6 R8 chan B" : "R5 R8 chan B", res_b, eb);
        chk(falls == (m ? 47 : 33), m ? "R4 edges" : "R3 edges", falls, m ? 47 : 33);
        chk(sel_n && sclk, "R3 select high clock high at end", {sel_n, sclk}, 3);
        chk(busy == 1'b0, "R10 busy low with valid", busy, 0);
        chk(setup_len >= HALF, "R2 setup phase", setup_len, HALF);
        @(negedge clk);
        chk(valid == 1'b0, "R9 valid one cycle", valid, 0);
        chk(res_a == ea && res_b == eb, "R9 results held", res_a, ea);
    endtask

    localparam logic [28:0] VEC [NVEC] = '{
        {1'b0, 14'h2A5C, 14'h15A3},
        {1'b0, 14'h2000, 14'h1FFF},
        {1'b1, 14'h3FFF, 14'h0001},
        {1'b1, 14'h0000, 14'h3FFE},
        {1'b0, 14'h0000, 14'h0000},
        {1'b1, 14'h1234, 14'h2ABC}
    };

    initial begin
        #(CLK_P * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(sel_n == 1 && sclk == 1, "R1 select/clock at reset", {sel_n, sclk}, 3);
        chk(busy == 0 && valid == 0, "R1 busy/valid at reset", {busy, valid}, 0);
        chk(res_a == 0 && res_b == 0, "R1 results at reset", res_a, 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        // R2 no clocking while idle
        chk(sclk == 1 && falls == 0, "R2 idle clock", falls, 0);

        for (int v = 0; v < NVEC; v++)
            run_frame(VEC[v][28], VEC[v][27:14], VEC[v][13:0]);

        // R12 phase length across all frames
        chk(bad_low == 0, "R12 low phase length", bad_low, 0);

        // R10 R11: start and mode flip mid-frame are ignored
        adc_a = 14'h0ABC; adc_b = 14'h3123; valids = 0;
        @(negedge clk); start = 1'b1; mode = 1'b0;
        @(negedge clk); start = 1'b0;
        repeat (40) @(negedge clk);
        start = 1'b1; mode = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_valid(2000);
        chk(falls == 33, "R11 frame length kept", falls, 33);
        chk(res_a == 16'h0ABC, "R10 chan A after ignored start", res_a, 16'h0ABC);
        chk(res_b == 16'hF123, "R11 chan B after mode flip", res_b, 16'hF123);
        repeat (10) @(negedge clk);
        chk(valids == 1, "R10 single valid", valids, 1);
        chk(sel_n == 1 && busy == 0, "R10 no restarted frame", {sel_n, busy}, 2);
        mode = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule